// File: doc/BRIEF.md
# Serial Divisible-by-Three Detector

This block watches a binary number that arrives one bit at a time, most significant bit first, and reports after every accepted bit whether the value received so far is a multiple of three. It keeps only the remainder of that value modulo three, held in two state bits. Each new bit doubles the value and adds the bit, so the remainder moves through a small fixed transition table.

A bit counts only when the bit-valid strobe is high at a rising clock edge. A synchronous reset starts a new number. The empty number counts as zero, so the light is on after reset. The light is decoded from the registered state alone. The two state bits are also driven to output pins so that they can be observed.

Top module: `mod3_serial_detector`

## Requirements
- R1: While `rst` is high at a rising edge, the state becomes 00 ({state_s1,state_s0}) and `light` reads 1 after that edge.
- R2: When `bit_vld` is low at a rising edge (and `rst` is low), the state and `light` keep their previous values, whatever `bit_in` is.
- R3: From state 00 an accepted bit 0 leads to 00 and an accepted bit 1 leads to 01.
- R4: From state 01 an accepted bit 0 leads to 10 and an accepted bit 1 leads to 00.
- R5: From state 10 an accepted bit 0 leads to 01 and an accepted bit 1 leads to 10.
- R6: `light` is 1 exactly when the state is 00, and 0 in the states 01, 10 and 11.
- R7: If the state ever holds the unused code 11, `light` reads 0, and the next accepted bit (0 or 1) moves the state to 00.
- R8: `light` has no combinational path from `bit_in` or `bit_vld`. Changing either input between clock edges leaves `light` unchanged.
- R9: Over any stream of accepted bits after reset, the state equals the remainder modulo 3 of the number received so far (0 as 00, 1 as 01, 2 as 10), and `light` is 1 exactly when that remainder is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_vld | input | 1 | Accept `bit_in` at this edge |
| bit_in | input | 1 | Next bit of the number, MSB first |
| light | output | 1 | High when the number so far is divisible by three |
| state_s1 | output | 1 | Upper state bit |
| state_s0 | output | 1 | Lower state bit |

## Verification
The unused code 11 cannot be reached from the ports: reset and every legal transition stay inside 00, 01 and 10. The bench therefore forces the state register to 11 between clock edges while `bit_vld` is low at that edge. It checks that `light` is low and the outputs show 11. It then presents one accepted bit and checks that the state returns to 00. This is repeated once with bit 0 and once with bit 1. Long random streams with gaps in `bit_vld` are compared against a remainder that the bench keeps itself.

// File: rtl/mod3_pkg.sv
package mod3_pkg;

    localparam int ST_W = 2;

    typedef enum logic [ST_W-1:0] {
        REM0   = 2'b00,
        REM1   = 2'b01,
        REM2   = 2'b10,
        ST_BAD = 2'b11
    } mod3_st_t;

    typedef struct packed {
        logic vld;
        logic b;
    } serial_in_t;

    // remainder after appending bit b: (2*r + b) mod 3
    function automatic mod3_st_t step(input mod3_st_t cur, input logic b);
        mod3_st_t nxt;
        unique case (cur)
            REM0:    nxt = b ? REM1 : REM0;
            REM1:    nxt = b ? REM0 : REM2;
            REM2:    nxt = b ? REM2 : REM1;
            default: nxt = REM0;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/mod3_next.sv
module mod3_next
    import mod3_pkg::*;
(
    input  mod3_st_t cur_st,
    input  logic     in_bit,
    output mod3_st_t nxt_st
);
    always_comb nxt_st = step(cur_st, in_bit);
endmodule

// File: rtl/mod3_state_reg.sv
module mod3_state_reg
    import mod3_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  mod3_st_t   d,
    output mod3_st_t   q
);
    mod3_st_t state_q;

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= REM0;
        else if (en)
            state_q <= d;
    end

    assign q = state_q;

    // R1
    reset_to_zero_chk: assert property (@(posedge clk) rst |=> (state_q == REM0));
endmodule

// File: rtl/mod3_light_dec.sv
module mod3_light_dec
    import mod3_pkg::*;
(
    input  mod3_st_t st,
    output logic     light
);
    always_comb light = ~st[1] & ~st[0];
endmodule

// File: rtl/mod3_serial_detector.sv
module mod3_serial_detector
    import mod3_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bit_vld,
    input  logic bit_in,
    output logic light,
    output logic state_s1,
    output logic state_s0
);
    serial_in_t sin;
    mod3_st_t   cur_st;
    mod3_st_t   nxt_st;

    assign sin.vld = bit_vld;
    assign sin.b   = bit_in;

    mod3_next u_next (
        .cur_st (cur_st),
        .in_bit (sin.b),
        .nxt_st (nxt_st)
    );

    mod3_state_reg u_reg (
        .clk (clk),
        .rst (rst),
        .en  (sin.vld),
        .d   (nxt_st),
        .q   (cur_st)
    );

    mod3_light_dec u_dec (
        .st    (cur_st),
        .light (light)
    );

    assign state_s1 = cur_st[1];
    assign state_s0 = cur_st[0];

    // R3
    from_rem0_chk: assert property (@(posedge clk) disable iff (rst)
        (cur_st == REM0 && bit_vld) |=> ({state_s1, state_s0} == ($past(bit_in) ? 2'b01 : 2'b00)));

    // R4
    from_rem1_chk: assert property (@(posedge clk) disable iff (rst)
        (cur_st == REM1 && bit_vld) |=> ({state_s1, state_s0} == ($past(bit_in) ? 2'b00 : 2'b10)));

    // R5
    from_rem2_chk: assert property (@(posedge clk) disable iff (rst)
        (cur_st == REM2 && bit_vld) |=> ({state_s1, state_s0} == ($past(bit_in) ? 2'b10 : 2'b01)));

    // R7
    bad_code_recover_chk: assert property (@(posedge clk) disable iff (rst)
        (cur_st == ST_BAD && bit_vld) |=> (!state_s1 && !state_s0 && light));
endmodule

// File: tb/mod3_serial_detector_tb_top.sv
module mod3_serial_detector_tb_top;
    import mod3_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_vld = 1'b0;
    logic bit_in = 1'b0;
    logic light, state_s1, state_s0;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    mod3_serial_detector dut_i (
        .clk      (clk),
        .rst      (rst),
        .bit_vld  (bit_vld),
        .bit_in   (bit_in),
        .light    (light),
        .state_s1 (state_s1),
        .state_s0 (state_s0)
    );

    // {vld, bit, exp_s1, exp_s0, exp_light}, applied in order after reset
    localparam int NV = 16;
    localparam logic [4:0] VEC [NV] = '{
        5'b11_01_0, 5'b10_10_0, 5'b11_10_0, 5'b10_01_0,
        5'b11_00_1, 5'b01_00_1, 5'b10_00_1, 5'b11_01_0,
        5'b00_01_0, 5'b11_00_1, 5'b11_01_0, 5'b10_10_0,
        5'b01_10_0, 5'b10_01_0, 5'b10_10_0, 5'b11_10_0
    };

    task automatic check(input string tag, input logic [1:0] exp_st, input logic exp_l);
        n_cmp++;
        if ({state_s1, state_s0} !== exp_st || light !== exp_l) begin
            n_bad++;
            $display("FAIL %s: state=%b light=%b expected state=%b light=%b",
                     tag, {state_s1, state_s0}, light, exp_st, exp_l);
        end
    endtask

    task automatic apply(input logic v, input logic b);
        @(negedge clk);
        bit_vld = v;
        bit_in  = b;
        @(posedge clk);
        #2;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(20 * 100000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

    initial begin
        logic [1:0] prev;
        int rem;
        // R1: reset state
        apply(1'b0, 1'b0);
        apply(1'b1, 1'b1);
        check("R1 reset", 2'b00, 1'b1);
        rst = 1'b0;
        prev = 2'b00;

        // table walk: R2..R6
        for (int i = 0; i < NV; i++) begin
            string tag;
            apply(VEC[i][4], VEC[i][3]);
            if (!VEC[i][4]) tag = "R2 hold";
            else if (prev == 2'b00) tag = "R3 from 00";
            else if (prev == 2'b01) tag = "R4 from 01";
            else tag = "R5 from 10";
            check(tag, VEC[i][2:1], VEC[i][0]);
            prev = VEC[i][2:1];
        end

        // R8: toggle inputs between edges; light must not move (state is 10)
        @(negedge clk);
        bit_vld = 1'b0;
        for (int k = 0; k < 4; k++) begin
            bit_in = ~bit_in;
            #1;
            check("R8 no comb path", 2'b10, 1'b0);
            bit_vld = ~bit_vld;
            #1;
            check("R8 no comb path", 2'b10, 1'b0);
        end
        bit_vld = 1'b0;

        // R1: reset mid-stream
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #2;
        check("R1 mid reset", 2'b00, 1'b1);
        rst = 1'b0;

        // R7: unused code, both bit values; previous edge has bit_vld low
        for (int b = 0; b < 2; b++) begin
            apply(1'b0, 1'b0);
            @(negedge clk);
            force dut_i.u_reg.state_q = ST_BAD;
            #1;
            release dut_i.u_reg.state_q;
            #1;
            check("R7 code 11 light low", 2'b11, 1'b0);
            check("R6 light off in 11", 2'b11, 1'b0);
            bit_vld = 1'b1;
            bit_in  = b[0];
            @(posedge clk);
            #2;
            check("R7 recover to 00", 2'b00, 1'b1);
        end

        // R9: random streams against a running remainder
        for (int s = 0; s < 6; s++) begin
            apply(1'b0, 1'b0);
            @(negedge clk);
            rst = 1'b1;
            @(posedge clk);
            #2;
            rst = 1'b0;
            rem = 0;
            for (int i = 0; i < 300; i++) begin
                logic v, b;
                v = ($urandom_range(0, 3) != 0);
                b = $urandom_range(0, 1);
                apply(v, b);
                if (v) rem = (rem * 2 + int'(b)) % 3;
                check("R9 stream", 2'(rem), rem == 0);
            end
        end

        bit_vld = 1'b0;
        finish_run();
    end
endmodule